// File: doc/BRIEF.md
# Self-Seeding PRBS31 Bit-Error Checker

This block measures the bit-error rate of a received pseudo-random test stream. The stream arrives from a deserializer as a parallel word of `LANES` bits (eight by default) with a valid strobe. A seed command makes the checker fill its local pattern generator from the received bits. Because the local state comes from the incoming data, no alignment with the transmitter has to be set up beforehand. Once seeded, the checker runs the pattern on its own, one word per valid cycle, in step with the input. It compares every lane and adds the result to two saturating counters: bits checked and bits in error.

The pattern is the maximal-length sequence of the polynomial x^31 + x^28 + 1, with period 2^31 - 1. The generator is unrolled so that it steps `LANES` positions in one cycle. A clear input zeroes both counters and leaves the generator and the lock alone. This lets a measurement window be restarted on a link that is already locked.

Top module: `prbs_self_seed_checker`

## Requirements
- R1: The predicted sequence obeys b[n] = b[n-31] XOR b[n-28]. Within each word, lane 0 carries the earliest bit in time and lane LANES-1 the latest. An error-free aligned stream therefore adds nothing to the error count.
- R2: A seed command starts seeding. The word that is valid in the same cycle as the command is the first seed word. Seeding consumes ceil(31/LANES) valid words (4 at LANES=8), and the latest 31 received bits become the generator state. Bits of seed words are neither compared nor counted. `locked_o` goes high in the cycle after the edge that takes the last seed word.
- R3: While locked, each valid word adds LANES to the bit count. It adds the number of lanes whose received bit differs from the prediction to the error count. Both counts are visible in the cycle after the word's edge.
- R4: After seeding, the generator advances only on its own predictions. A corrupted received bit is counted once and does not disturb the prediction of later bits.
- R5: A cycle with `rx_valid_i` low neither advances the generator nor changes either counter, whatever the data lines carry.
- R6: Both counters stop at 2^CNT_W - 1 and never wrap.
- R7: A clear zeroes both counters on the next edge and wins over a valid word in the same cycle. The generator still advances on that word, and the lock is kept.
- R8: A seed command while locked drops `locked_o` on the next edge and reseeds from the incoming words. The counters keep their values.
- R9: After reset both counters are zero and `locked_o` is low. Valid words that arrive before any seed command are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid_i | input | 1 | Received word valid |
| rx_data_i | input | LANES (8) | Received word, lane 0 earliest bit |
| seed_i | input | 1 | Start a seeding phase |
| clr_i | input | 1 | Zero both counters |
| err_count_o | output | CNT_W (48) | Saturating count of mismatched bits |
| bit_count_o | output | CNT_W (48) | Saturating count of compared bits |
| locked_o | output | 1 | Seeding finished, comparison active |

## Verification
The bench keeps the default eight lanes and the x^31 + x^28 + 1 taps, so the real word-level unrolling and the four-word seeding are exercised. It narrows `CNT_W` to 10 bits, so both counters reach their ceiling of 1023 within about 130 words. This makes the saturation of both the bit count and the error count reachable in a short directed run. Reseeding at a jumped phase of the stream, clears that collide with errored words, and idle cycles with garbage data are all run at these same values.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_LOCK = 2'd2
  } chk_state_e;

endpackage

// File: rtl/prbs_word_step.sv
// Unrolled multi-step advance of a Fibonacci LFSR history.
// hist bit 0 holds the most recent bit, bit PRBS_LEN-1 the oldest.
module prbs_word_step #(
  parameter int LANES    = 8,
  parameter int PRBS_LEN = 31,
  parameter int TAP      = 28
) (
  input  logic [PRBS_LEN-1:0] hist_i,
  input  logic [LANES-1:0]    data_i,
  input  logic                load_i,
  output logic [PRBS_LEN-1:0] hist_o,
  output logic [LANES-1:0]    pred_o
);

  logic [PRBS_LEN-1:0] chain [0:LANES];
  logic [LANES-1:0]    push_bit;

  assign chain[0] = hist_i;

  for (genvar g = 0; g < LANES; g++) begin : g_step
    // b[n] = b[n-PRBS_LEN] ^ b[n-TAP]
    assign pred_o[g]    = chain[g][PRBS_LEN-1] ^ chain[g][TAP-1];
    assign push_bit[g]  = load_i ? data_i[g] : pred_o[g];
    assign chain[g+1]   = {chain[g][PRBS_LEN-2:0], push_bit[g]};
  end

  assign hist_o = chain[LANES];

endmodule

// File: rtl/prbs_seed_ctrl.sv
module prbs_seed_ctrl
  import prbs_chk_pkg::*;
#(
  parameter int SEED_WORDS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_i,
  input  logic seed_i,
  output logic load_o,
  output logic advance_o,
  output logic compare_o,
  output logic locked_o
);

  localparam int CW = $clog2(SEED_WORDS + 1);
  localparam logic [CW-1:0] LAST = CW'(SEED_WORDS);

  chk_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign load_o    = seed_i | (state_q == ST_SEED);
  assign advance_o = valid_i & (load_o | (state_q == ST_LOCK));
  assign compare_o = valid_i & ~seed_i & (state_q == ST_LOCK);
  assign locked_o  = (state_q == ST_LOCK);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_inc = '0;
    if (seed_i) begin
      cnt_inc = valid_i ? CW'(1) : '0;
      cnt_d   = cnt_inc;
      state_d = (cnt_inc == LAST) ? ST_LOCK : ST_SEED;
    end else if ((state_q == ST_SEED) && valid_i) begin
      cnt_inc = cnt_q + CW'(1);
      cnt_d   = cnt_inc;
      if (cnt_inc == LAST) state_d = ST_LOCK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/prbs_sat_counter.sv
module prbs_sat_counter #(
  parameter int W  = 48,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{(W+1-IW){1'b0}}, inc_i};

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (en_i)  cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/prbs_self_seed_checker.sv
module prbs_self_seed_checker #(
  parameter int LANES    = 8,
  parameter int PRBS_LEN = 31,
  parameter int TAP      = 28,
  parameter int CNT_W    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid_i,
  input  logic [LANES-1:0] rx_data_i,
  input  logic             seed_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] err_count_o,
  output logic [CNT_W-1:0] bit_count_o,
  output logic             locked_o
);

  localparam int SEED_WORDS = (PRBS_LEN + LANES - 1) / LANES;
  localparam int IW         = $clog2(LANES + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                load, advance, compare;
  logic [PRBS_LEN-1:0] hist_q, hist_d, hist_step;
  logic [LANES-1:0]    pred, mism;
  logic [IW-1:0]       err_inc;

  prbs_seed_ctrl #(.SEED_WORDS(SEED_WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .valid_i   (rx_valid_i),
    .seed_i    (seed_i),
    .load_o    (load),
    .advance_o (advance),
    .compare_o (compare),
    .locked_o  (locked_o)
  );

  prbs_word_step #(.LANES(LANES), .PRBS_LEN(PRBS_LEN), .TAP(TAP)) u_step (
    .hist_i (hist_q),
    .data_i (rx_data_i),
    .load_i (load),
    .hist_o (hist_step),
    .pred_o (pred)
  );

  always_comb begin
    hist_d = hist_q;
    if (advance) hist_d = hist_step;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hist_q <= '0;
    else             hist_q <= hist_d;
  end

  assign mism = (rx_data_i ^ pred) & {LANES{compare}};

  always_comb begin
    err_inc = '0;
    for (int i = 0; i < LANES; i++) err_inc = err_inc + IW'(mism[i]);
  end

  prbs_sat_counter #(.W(CNT_W), .IW(IW)) u_err_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (clr_i),
    .en_i  (compare),
    .inc_i (err_inc),
    .cnt_o (err_count_o)
  );

  prbs_sat_counter #(.W(CNT_W), .IW(IW)) u_bit_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (clr_i),
    .en_i  (compare),
    .inc_i (IW'(LANES)),
    .cnt_o (bit_count_o)
  );

endmodule

// File: rtl/prbs_self_seed_checker_chk.sv
module prbs_self_seed_checker_chk #(
  parameter int LANES = 8,
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid_i,
  input logic             seed_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] err_count_o,
  input logic [CNT_W-1:0] bit_count_o,
  input logic             locked_o
);

  p_lock_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(rx_valid_i));

  p_err_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> (err_count_o - $past(err_count_o)) <= CNT_W'(LANES));

  p_err_le_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_count_o <= bit_count_o);

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> (bit_count_o >= $past(bit_count_o)) &&
                      (err_count_o >= $past(err_count_o)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (err_count_o == '0) && (bit_count_o == '0));

  p_seed_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seed_i) |-> !locked_o);

  p_unlocked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(locked_o) && !$past(clr_i)) |-> ($stable(err_count_o) && $stable(bit_count_o)));

endmodule

bind prbs_self_seed_checker prbs_self_seed_checker_chk #(
  .LANES (LANES),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid_i  (rx_valid_i),
  .seed_i      (seed_i),
  .clr_i       (clr_i),
  .err_count_o (err_count_o),
  .bit_count_o (bit_count_o),
  .locked_o    (locked_o)
);

// File: tb/prbs_self_seed_checker_bench.sv
`timescale 1ns/1ps
module prbs_self_seed_checker_bench;

  localparam int LANES = 8;
  localparam int CNT_W = 10;
  localparam longint MAXC = (64'd1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             rx_valid_i;
  logic [LANES-1:0] rx_data_i;
  logic             seed_i;
  logic             clr_i;
  logic [CNT_W-1:0] err_count_o;
  logic [CNT_W-1:0] bit_count_o;
  logic             locked_o;

  prbs_self_seed_checker #(.LANES(LANES), .CNT_W(CNT_W)) u_prbs_self_seed_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .seed_i      (seed_i),
    .clr_i       (clr_i),
    .err_count_o (err_count_o),
    .bit_count_o (bit_count_o),
    .locked_o    (locked_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  int     n_checks = 0;
  int     n_fails  = 0;
  longint exp_err  = 0;
  longint exp_bits = 0;
  logic [30:0] tx_hist = 31'h2AC35F17;   // bit 0 = newest transmitted bit

  // transmitter model: b[n] = b[n-31] ^ b[n-28], lane 0 sent first
  task automatic tx_word(output logic [LANES-1:0] w);
    for (int i = 0; i < LANES; i++) begin
      logic b;
      b = tx_hist[30] ^ tx_hist[27];
      tx_hist = {tx_hist[29:0], b};
      w[i] = b;
    end
  endtask

  function automatic longint sat_add(longint a, longint b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_counts(string req);
    check({req, " err"}, longint'(err_count_o), exp_err);
    check({req, " bits"}, longint'(bit_count_o), exp_bits);
  endtask

  task automatic drive(logic [LANES-1:0] d, logic seed, logic clr);
    @(negedge clk);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    seed_i     = seed;
    clr_i      = clr;
  endtask

  task automatic gap();
    @(negedge clk);
    rx_valid_i = 1'b0;
    rx_data_i  = 8'h5A;
    seed_i     = 1'b0;
    clr_i      = 1'b0;
  endtask

  // send n clean words while locked
  task automatic send_clean(int n);
    for (int k = 0; k < n; k++) begin
      logic [LANES-1:0] w;
      tx_word(w);
      drive(w, 1'b0, 1'b0);
      exp_bits = sat_add(exp_bits, LANES);
    end
  endtask

  task automatic seed_stream();
    logic [LANES-1:0] w;
    tx_word(w); drive(w, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tx_word(w); drive(w, 1'b0, 1'b0);
    end
  endtask

  task automatic t_reset();
    check("R9 reset locked", locked_o, 0);
    check_counts("R9 reset");
  endtask

  task automatic t_idle_words();
    logic [LANES-1:0] w;
    for (int k = 0; k < 3; k++) begin tx_word(w); drive(w, 1'b0, 1'b0); end
    gap();
    check("R9 no seed locked", locked_o, 0);
    check_counts("R9 no seed");
  endtask

  task automatic t_seed();
    logic [LANES-1:0] w;
    tx_word(w); drive(w, 1'b1, 1'b0);
    tx_word(w); drive(w, 1'b0, 1'b0);
    tx_word(w); drive(w, 1'b0, 1'b0);
    gap();
    check("R2 three seed words locked", locked_o, 0);
    tx_word(w); drive(w, 1'b0, 1'b0);
    gap();
    check("R2 fourth seed word locked", locked_o, 1);
    check_counts("R2 seed words not counted");
  endtask

  task automatic t_clean_with_gaps();
    for (int k = 0; k < 20; k++) begin
      send_clean(1);
      if (k % 3 == 0) begin gap(); gap(); end
    end
    gap();
    check_counts("R1 R5 clean stream with idle gaps");
  endtask

  task automatic t_errors();
    logic [LANES-1:0] w;
    tx_word(w); drive(w ^ 8'h01, 1'b0, 1'b0);
    exp_bits = sat_add(exp_bits, LANES); exp_err = sat_add(exp_err, 1);
    gap();
    check_counts("R3 lane 0 error");
    tx_word(w); drive(w ^ 8'h80, 1'b0, 1'b0);
    exp_bits = sat_add(exp_bits, LANES); exp_err = sat_add(exp_err, 1);
    gap();
    check_counts("R3 lane 7 error");
    tx_word(w); drive(w ^ 8'h2C, 1'b0, 1'b0);
    exp_bits = sat_add(exp_bits, LANES); exp_err = sat_add(exp_err, 3);
    send_clean(10);
    gap();
    check_counts("R4 three errors then clean words");
  endtask

  task automatic t_clear();
    logic [LANES-1:0] w;
    tx_word(w); drive(~w, 1'b0, 1'b1);
    exp_err = 0; exp_bits = 0;
    gap();
    check_counts("R7 clear beats errored word");
    check("R7 lock kept", locked_o, 1);
    send_clean(5);
    gap();
    check_counts("R7 generator kept across clear");
  endtask

  task automatic t_reseed();
    logic [LANES-1:0] w;
    for (int k = 0; k < 100; k++) tx_word(w);   // jump phase
    tx_word(w); drive(w, 1'b1, 1'b0);
    gap();
    check("R8 lock dropped", locked_o, 0);
    check_counts("R8 counters kept");
    for (int k = 0; k < 3; k++) begin tx_word(w); drive(w, 1'b0, 1'b0); end
    gap();
    check("R8 relocked", locked_o, 1);
    send_clean(6);
    gap();
    check_counts("R8 R1 aligned after reseed");
  endtask

  task automatic t_sat_bits();
    send_clean(140);
    gap();
    check("R6 bit count saturates", longint'(bit_count_o), MAXC);
    check_counts("R6 bits");
  endtask

  task automatic t_sat_err();
    logic [LANES-1:0] w;
    tx_word(w); drive(w, 1'b0, 1'b1);
    exp_err = 0; exp_bits = 0;
    for (int k = 0; k < 130; k++) begin
      tx_word(w); drive(~w, 1'b0, 1'b0);
      exp_bits = sat_add(exp_bits, LANES);
      exp_err  = sat_add(exp_err, LANES);
    end
    gap();
    check("R6 error count saturates", longint'(err_count_o), MAXC);
    send_clean(4);
    gap();
    check_counts("R6 saturated counts hold");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    rx_valid_i = 1'b0;
    rx_data_i  = '0;
    seed_i     = 1'b0;
    clr_i      = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_words();
    t_seed();
    t_clean_with_gaps();
    t_errors();
    t_clear();
    t_reseed();
    t_sat_bits();
    t_sat_err();
    finish_run();
  end

endmodule